// File: doc/BRIEF.md
# Program/Erase Busy Status Generator

This block runs the device-side timer for an embedded program or erase operation and builds the byte that a host sees when it reads during that time. A command decoder pulses a program strobe or an erase strobe for one clock. The block then stays busy for a fixed number of clock cycles, set by a parameter for each operation. While it is busy, every read returns a status byte instead of array data. When the timer runs out, reads return the array contents unchanged.

The status byte supports two completion-detection methods. The first is the inverted top bit. During a program operation, bit 7 shows the complement of bit 7 of the byte being written. During an erase it shows 0, because the erased target value is all ones. The second is a toggling bit 6. It starts at 0 when an operation begins and flips once for each read strobe taken while the block is busy. Bits 5:0 always pass the array data through. The array itself and the command decoding are outside this block. The array behaviour this block relies on is that an erased cell reads 1 and programming can only clear bits.

Top module: `pe_status_gen`

## Requirements
- R1: While rst_ni is low, busy_o is 0 and rdata_o equals rd_data_i.
- R2: When the block is idle, a prog_start_i pulse sets busy_o from the next cycle for exactly PROG_CYCLES cycles.
- R3: When the block is idle, an erase_start_i pulse sets busy_o from the next cycle for exactly ERASE_CYCLES cycles.
- R4: A start strobe of either kind that arrives while busy_o is 1 is ignored. This includes the final busy cycle. Such a strobe changes neither the busy span nor the status bit 7 in use.
- R5: If both strobes arrive together while the block is idle, the erase is taken: the busy span is ERASE_CYCLES and bit 7 follows R7.
- R6: During a program operation, rdata_o[7] is the inverse of the value load_msb_i had in the cycle the start was taken.
- R7: During an erase operation, rdata_o[7] is 0.
- R8: During a busy span, rdata_o[6] is 0 in the first busy cycle. It then inverts after each clock edge at which rd_i was 1 while busy, and holds otherwise.
- R9: During a busy span, rdata_o[5:0] equals rd_data_i[5:0].
- R10: While busy_o is 0, rdata_o equals rd_data_i on all eight bits.
- R11: A read in the cycle a start is taken returns true data. A read in the last busy cycle returns status. The next cycle returns true data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_start_i | input | 1 | One-cycle program start strobe from the decoder |
| erase_start_i | input | 1 | One-cycle erase start strobe from the decoder |
| load_msb_i | input | 1 | Bit 7 of the byte loaded for programming, valid with prog_start_i |
| rd_i | input | 1 | Read strobe, one per host read access |
| rd_data_i | input | 8 | True data read from the array |
| busy_o | output | 1 | Embedded operation in progress |
| rdata_o | output | 8 | Byte returned to the host: status while busy, array data otherwise |

## Verification
Two functions can land on the same clock edge. One is the timer's expiry, or a new start. The other is a read strobe, which advances the toggle bit and selects status or data. The bench places a read in the cycle a start is taken, a read in the final busy cycle, and a start strobe in that same final cycle. It also starts a new operation one cycle after busy falls. A behavioural model steps on every edge and predicts busy and every bit of the read byte. A wrong choice of which event wins shows up as a one-cycle error in busy_o or in bit 6 or bit 7.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pe_op_timer.sv
module pe_op_timer
  import pe_status_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 2500,
  parameter int unsigned ERASE_CYCLES = 500000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_start_i,
  input  logic erase_start_i,
  input  logic load_msb_i,
  output logic accept_o,
  output logic busy_o,
  output logic poll_bit_o
);
  localparam int unsigned MAX_CYC = max_u(PROG_CYCLES, ERASE_CYCLES);
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);

  op_e              req_op;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             poll_q;

  // erase outranks program when both strobes coincide
  always_comb begin
    if (erase_start_i)     req_op = OP_ERASE;
    else if (prog_start_i) req_op = OP_PROG;
    else                   req_op = OP_IDLE;
  end

  assign accept_o = !busy_q && (req_op != OP_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      poll_q <= 1'b0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= (req_op == OP_ERASE) ? ERASE_LAST : PROG_LAST;
      poll_q <= (req_op == OP_ERASE) ? 1'b0 : ~load_msb_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign poll_bit_o = poll_q;
endmodule

// File: rtl/pe_toggle.sv
module pe_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tog_q <= 1'b0;
    else if (accept_i)        tog_q <= 1'b0;
    else if (busy_i && rd_i)  tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/pe_status_mux.sv
module pe_status_mux #(
  parameter int unsigned DW = 8
) (
  input  logic          busy_i,
  input  logic          poll_bit_i,
  input  logic          tog_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned LOW_W = DW - 2;

  always_comb begin
    if (busy_i) rdata_o = {poll_bit_i, tog_i, rd_data_i[LOW_W-1:0]};
    else        rdata_o = rd_data_i;
  end
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen #(
  parameter int unsigned PROG_CYCLES  = 2500,
  parameter int unsigned ERASE_CYCLES = 500000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prog_start_i,
  input  logic       erase_start_i,
  input  logic       load_msb_i,
  input  logic       rd_i,
  input  logic [7:0] rd_data_i,
  output logic       busy_o,
  output logic [7:0] rdata_o
);
  logic accept;
  logic busy;
  logic poll_bit;
  logic tog;

  pe_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_start_i (prog_start_i),
    .erase_start_i(erase_start_i),
    .load_msb_i   (load_msb_i),
    .accept_o     (accept),
    .busy_o       (busy),
    .poll_bit_o   (poll_bit)
  );

  pe_toggle u_toggle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .busy_i  (busy),
    .rd_i    (rd_i),
    .tog_o   (tog)
  );

  pe_status_mux #(.DW(8)) u_mux (
    .busy_i    (busy),
    .poll_bit_i(poll_bit),
    .tog_i     (tog),
    .rd_data_i (rd_data_i),
    .rdata_o   (rdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/pe_status_gen_chk.sv
module pe_status_gen_chk #(
  parameter int unsigned PROG_CYCLES  = 2500,
  parameter int unsigned ERASE_CYCLES = 500000000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prog_start_i,
  input logic       erase_start_i,
  input logic       load_msb_i,
  input logic       rd_i,
  input logic [7:0] rd_data_i,
  input logic       busy_o,
  input logic [7:0] rdata_o
);
  logic [31:0] rem_q;
  logic        erase_q;
  logic        msb_q;
  logic        take;

  assign take = !busy_o && (prog_start_i || erase_start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      erase_q <= 1'b0;
      msb_q   <= 1'b0;
    end else if (take) begin
      rem_q   <= erase_start_i ? ERASE_CYCLES : PROG_CYCLES;
      erase_q <= erase_start_i;
      msb_q   <= load_msb_i;
    end else if (rem_q != 0) begin
      rem_q <= rem_q - 1;
    end
  end

  AST_BUSY_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (rem_q != 0)); // R3
  AST_BUSY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && prog_start_i) |=> busy_o); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rem_q > 1 && (prog_start_i || erase_start_i)) |=> busy_o); // R4
  AST_ERASE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && prog_start_i && erase_start_i) |=> !rdata_o[7]); // R5
  AST_PROG_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !erase_q) |-> rdata_o[7] == ~msb_q); // R6
  AST_ERASE_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && erase_q) |-> !rdata_o[7]); // R7
  AST_TOG_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> !rdata_o[6]); // R8
  AST_TOG_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && $past(rd_i)) |-> rdata_o[6] != $past(rdata_o[6])); // R8
  AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(rd_i)) |-> rdata_o[6] == $past(rdata_o[6])); // R8
  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rdata_o[5:0] == rd_data_i[5:0]); // R9
  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> rdata_o == rd_data_i); // R10

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_STATE: assert (!busy_o && rdata_o == rd_data_i); // R1
    end
  end
endmodule

bind pe_status_gen pe_status_gen_chk #(
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prog_start_i (prog_start_i),
  .erase_start_i(erase_start_i),
  .load_msb_i   (load_msb_i),
  .rd_i         (rd_i),
  .rd_data_i    (rd_data_i),
  .busy_o       (busy_o),
  .rdata_o      (rdata_o)
);

// File: tb/tb_pe_status_gen.sv
`timescale 1ns/1ps
module tb_pe_status_gen;
  localparam int PROG  = 6;
  localparam int ERASE = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pg = 1'b0, er = 1'b0, lmsb = 1'b0, rd = 1'b0;
  logic [7:0] rdd = 8'h00;
  logic       busy;
  logic [7:0] rdata;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1";

  // reference model state
  int m_rem = 0;
  bit m_erase = 0;
  bit m_b7 = 0;
  bit m_tog = 0;

  always #10 clk = ~clk;

  pe_status_gen #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_start_i(pg), .erase_start_i(er),
    .load_msb_i(lmsb), .rd_i(rd), .rd_data_i(rdd), .busy_o(busy), .rdata_o(rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_erase = 0; m_b7 = 0; m_tog = 0;
    end else if (m_rem == 0 && (pg || er)) begin
      m_rem = er ? ERASE : PROG;
      m_erase = er;
      m_b7 = er ? 1'b0 : ~lmsb;
      m_tog = 0;
    end else if (m_rem > 0) begin
      if (rd) m_tog = ~m_tog;
      m_rem = m_rem - 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic       e_busy;
      logic [7:0] e_data;
      e_busy = (m_rem > 0);
      e_data = e_busy ? {m_b7, m_tog, rdd[5:0]} : rdd;
      checks++;
      if (busy !== e_busy) begin
        errors++;
        $display("FAIL %s/%s busy act=%b exp=%b t=%0t", phase,
                 m_erase ? "R3" : "R2", busy, e_busy, $time);
      end else if (rdata !== e_data) begin
        errors++;
        if (!e_busy)
          $display("FAIL %s/R10 rdata act=%h exp=%h", phase, rdata, e_data);
        else if (rdata[7] !== e_data[7])
          $display("FAIL %s/%s bit7 act=%b exp=%b", phase,
                   m_erase ? "R7" : "R6", rdata[7], e_data[7]);
        else if (rdata[6] !== e_data[6])
          $display("FAIL %s/R8 bit6 act=%b exp=%b", phase, rdata[6], e_data[6]);
        else
          $display("FAIL %s/R9 low act=%h exp=%h", phase, rdata[5:0], e_data[5:0]);
      end
    end
  end

  task automatic step(input logic p, input logic e, input logic m, input logic r);
    @(posedge clk);
    #5;
    pg = p; er = e; lmsb = m; rd = r;
    rdd = 8'($urandom);
  endtask

  task automatic idle_n(input int n, input logic r);
    for (int i = 0; i < n; i++) step(0, 0, 0, r);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    idle_n(4, 1);
    step(1, 0, 1, 1);            // strobes during reset
    idle_n(2, 1);
    @(posedge clk); #5 rst_n = 1'b1;
    idle_n(2, 0);

    phase = "R2";                // load 0x35: msb 0
    step(1, 0, 0, 1);
    idle_n(PROG + 2, 1);
    phase = "R6";                // msb 1, sparse reads
    step(1, 0, 1, 0);
    for (int i = 0; i < PROG + 2; i++) step(0, 0, 0, (i % 3) == 0);

    phase = "R3";
    step(0, 1, 1, 0);
    for (int i = 0; i < ERASE + 2; i++) step(0, 0, 0, i[0]);
    phase = "R7";
    step(0, 1, 0, 1);
    idle_n(ERASE + 1, 1);

    phase = "R4";                // strobes mid-busy and in final busy cycle
    step(1, 0, 0, 1);
    step(0, 1, 1, 1);
    step(1, 0, 1, 0);
    idle_n(PROG - 3, 1);
    step(1, 1, 1, 1);            // last busy cycle: ignored
    step(1, 0, 1, 1);            // idle again: taken
    idle_n(PROG + 1, 0);

    phase = "R5";
    step(1, 1, 0, 1);
    idle_n(ERASE + 2, 1);

    phase = "R11";               // back-to-back, reads at start and expiry
    step(1, 0, 0, 1);
    idle_n(PROG - 1, 0);
    step(0, 0, 0, 1);
    step(0, 1, 0, 1);
    idle_n(ERASE + 2, 0);

    phase = "R8";
    step(1, 0, 1, 1);
    for (int i = 0; i < PROG + 1; i++) step(0, 0, 0, (i < 2));
    phase = "R9";
    step(0, 1, 0, 1);
    idle_n(ERASE + 1, 1);
    phase = "R10";
    idle_n(6, 1);

    @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule